// File: doc/BRIEF.md
# Flying-Capacitor Redundant State Selector

This block turns per-phase output-level requests from an upstream modulator into 6-bit switch command vectors for a three-phase, four-level nested neutral-point-clamped inverter. Each phase has two flying capacitors. The block uses the redundant switching states of the two middle levels to push each capacitor back toward one third of the dc-bus voltage. The outer levels have a single fixed pattern each.

For every sample the block computes the bus third in fixed point and subtracts it from each capacitor sample to get that capacitor's deviation. It then combines the sign of the deviation with the sign of the phase current. A negative product selects the B state of the level; a zero or positive product selects the A state. Level 2 looks only at the upper capacitor. Level 1 looks only at the lower capacitor. Inputs are captured on a sample strobe, and the command vectors change on that clock edge. The three phases are handled in parallel and independently.

Top module: `fc_state_sel`

## Requirements
- R1: While reset is held and after it is released, every phase drives 000111 until the first strobed sample is taken.
- R2: A phase whose level code is 3 drives 111000, and level code 0 drives 000111, whatever its capacitor and current samples are. Vectors are written s1 first, so s1 is bit 5 of a phase field.
- R3: At level code 2 a phase drives 101100 when the product of the upper-capacitor deviation and the phase current is negative. Otherwise it drives 011001. The lower capacitor has no effect on this choice.
- R4: At level code 1 a phase drives 100110 when the product of the lower-capacitor deviation and the phase current is negative. Otherwise it drives 001101. The upper capacitor has no effect on this choice.
- R5: A deviation or current of exactly zero gives a zero product, and a zero product selects the A pattern (011001 or 001101).
- R6: The bus third is floor((bus × 21845 + 32768) / 65536), computed on signed values. Deviation is the capacitor sample minus this value.
- R7: Inputs are taken only on a clock edge with the strobe high. The new vectors are visible right after that edge. With the strobe low, the vectors hold.
- R8: Phase p uses level bits [2p+1:2p], sample bits [16p+15:16p] and command bits [6p+5:6p]. A phase's command depends only on its own inputs and on the bus sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; inputs are taken when high |
| lvl_req | input | 6 | Level code per phase, 2 bits each |
| vc_up | input | 48 | Upper flying-capacitor voltage per phase, signed 16-bit |
| vc_dn | input | 48 | Lower flying-capacitor voltage per phase, signed 16-bit |
| i_ph | input | 48 | Phase current per phase, signed 16-bit |
| v_bus | input | 16 | DC-bus voltage, signed 16-bit |
| sw_cmd | output | 18 | Switch vector per phase, 6 bits each, s1 in the top bit |

## Verification
The bench builds the block with its defaults: three phases, 16-bit samples, and a 21845/65536 third constant. With these values its own integer model computes the rounded bus third, including the negative-bus rounding edge. Random samples cover every level, both current signs and both deviation signs on all phases together. Directed samples place a deviation exactly on zero, place the current on zero, and move the capacitor that is not used to show that it has no effect.

// File: rtl/fc_state_sel.sv
module fc_state_sel #(
  parameter int W     = 16,
  parameter int NPH   = 3,
  parameter int K_NUM = 21845,
  parameter int K_SH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_vld,
  input  logic [NPH*2-1:0]   lvl_req,
  input  logic [NPH*W-1:0]   vc_up,
  input  logic [NPH*W-1:0]   vc_dn,
  input  logic [NPH*W-1:0]   i_ph,
  input  logic [W-1:0]       v_bus,
  output logic [NPH*6-1:0]   sw_cmd
);
  localparam int PW = W + K_SH + 2;
  localparam int DW = W + 2;
  localparam logic [5:0] PAT_L3 = 6'b111000;
  localparam logic [5:0] PAT_2A = 6'b011001;
  localparam logic [5:0] PAT_2B = 6'b101100;
  localparam logic [5:0] PAT_1A = 6'b001101;
  localparam logic [5:0] PAT_1B = 6'b100110;
  localparam logic [5:0] PAT_L0 = 6'b000111;

  logic signed [PW-1:0] bus_x, prod, rnd, third_w;
  logic signed [DW-1:0] third;

  assign bus_x   = $signed({{(PW-W){v_bus[W-1]}}, v_bus});
  assign prod    = bus_x * $signed(PW'(K_NUM));
  assign rnd     = prod + $signed(PW'(1) << (K_SH - 1));
  assign third_w = rnd >>> K_SH;
  assign third   = third_w[DW-1:0];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [1:0]          lvl;
    logic signed [DW-1:0] dev_u, dev_d, cur;
    logic                neg_u, neg_d;
    logic [5:0]          nxt, cmd_q;

    assign lvl   = lvl_req[2*p +: 2];
    assign cur   = DW'($signed(i_ph[W*p +: W]));
    assign dev_u = DW'($signed(vc_up[W*p +: W])) - third;
    assign dev_d = DW'($signed(vc_dn[W*p +: W])) - third;
    assign neg_u = (dev_u != '0) && (cur != '0) && (dev_u[DW-1] ^ cur[DW-1]);
    assign neg_d = (dev_d != '0) && (cur != '0) && (dev_d[DW-1] ^ cur[DW-1]);

    always_comb begin
      unique case (lvl)
        2'd3:    nxt = PAT_L3;
        2'd2:    nxt = neg_u ? PAT_2B : PAT_2A;
        2'd1:    nxt = neg_d ? PAT_1B : PAT_1A;
        default: nxt = PAT_L0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       cmd_q <= PAT_L0;
      else if (smp_vld) cmd_q <= nxt;
    end

    assign sw_cmd[6*p +: 6] = cmd_q;

    assert_outer_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && lvl_req[2*p +: 2] == 2'd3) |=> (sw_cmd[6*p +: 6] == PAT_L3));
    assert_outer_bot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && lvl_req[2*p +: 2] == 2'd0) |=> (sw_cmd[6*p +: 6] == PAT_L0));
    assert_mid_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && lvl_req[2*p +: 2] == 2'd2) |=>
        (sw_cmd[6*p +: 6] == PAT_2A || sw_cmd[6*p +: 6] == PAT_2B));
    assert_mid_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && lvl_req[2*p +: 2] == 2'd1) |=>
        (sw_cmd[6*p +: 6] == PAT_1A || sw_cmd[6*p +: 6] == PAT_1B));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(sw_cmd[6*p +: 6]));
    assert_three_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sw_cmd[6*p +: 6]) == 3);
  end
endmodule

// File: tb/test_fc_state_sel.sv
module test_fc_state_sel;
  localparam int W = 16;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [NPH*2-1:0] lvl_req = '0;
  logic [NPH*W-1:0] vc_up = '0, vc_dn = '0, i_ph = '0;
  logic [W-1:0] v_bus = '0;
  logic [NPH*6-1:0] sw_cmd;

  int errs = 0, checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fc_state_sel i_fc_state_sel (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .lvl_req(lvl_req),
    .vc_up(vc_up), .vc_dn(vc_dn), .i_ph(i_ph), .v_bus(v_bus), .sw_cmd(sw_cmd)
  );

  function automatic longint third_of(longint b);
    return (b * 21845 + 32768) >>> 16;
  endfunction

  function automatic logic [5:0] model(int lv, longint cu, longint cd, longint cur, longint b);
    longint du, dd;
    du = cu - third_of(b);
    dd = cd - third_of(b);
    case (lv)
      3: return 6'b111000;
      2: return (du * cur < 0) ? 6'b101100 : 6'b011001;
      1: return (dd * cur < 0) ? 6'b100110 : 6'b001101;
      default: return 6'b000111;
    endcase
  endfunction

  task automatic chk(int p, string req, logic [5:0] exp);
    checks++;
    if (sw_cmd[6*p +: 6] !== exp) begin
      errs++;
      $display("FAIL %s phase %0d: got %b expected %b", req, p, sw_cmd[6*p +: 6], exp);
    end
  endtask

  task automatic set_ph(int p, int lv, int cu, int cd, int cur);
    lvl_req[2*p +: 2] = 2'(lv);
    vc_up[W*p +: W] = 16'(cu);
    vc_dn[W*p +: W] = 16'(cd);
    i_ph[W*p +: W] = 16'(cur);
  endtask

  task automatic strobe();
    smp_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  function automatic logic [5:0] exp_ph(int p);
    return model(int'(lvl_req[2*p +: 2]),
                 longint'($signed(vc_up[W*p +: W])), longint'($signed(vc_dn[W*p +: W])),
                 longint'($signed(i_ph[W*p +: W])), longint'($signed(v_bus)));
  endfunction

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [5:0] held;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    for (int p = 0; p < NPH; p++) chk(p, "R1 in reset", 6'b000111);
    rst_n = 1'b1;
    set_ph(0, 3, 500, 500, 100);
    @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < NPH; p++) chk(p, "R1 before first sample", 6'b000111);

    v_bus = 16'd300;
    set_ph(0, 3, -9000, 9000, -7);
    set_ph(1, 0, 9000, -9000, 7);
    set_ph(2, 2, 101, -5000, -3);
    strobe();
    chk(0, "R2 level 3", 6'b111000);
    chk(1, "R2 level 0", 6'b000111);
    chk(2, "R3 level 2 negative product", 6'b101100);

    set_ph(2, 2, 101, 5000, -3);
    strobe();
    chk(2, "R3 lower cap has no effect", 6'b101100);

    set_ph(0, 2, 100, 0, -50);
    set_ph(1, 1, 0, 100, -50);
    set_ph(2, 2, 150, 0, 0);
    strobe();
    chk(0, "R5 zero deviation level 2", 6'b011001);
    chk(1, "R5 zero deviation level 1", 6'b001101);
    chk(2, "R5 zero current", 6'b011001);

    set_ph(0, 1, -3000, 99, 40);
    set_ph(1, 1, 3000, 99, 40);
    set_ph(2, 1, 0, 101, 40);
    strobe();
    chk(0, "R4 level 1 negative product", 6'b100110);
    chk(1, "R4 upper cap has no effect", 6'b100110);
    chk(2, "R4 positive product", 6'b001101);

    v_bus = -16'sd300;
    set_ph(0, 2, -100, 0, 9);
    set_ph(1, 2, -101, 0, 9);
    set_ph(2, 1, 0, -99, -9);
    strobe();
    chk(0, "R6 negative bus rounding zero dev", 6'b011001);
    chk(1, "R6 negative bus rounding", 6'b101100);
    chk(2, "R6 negative bus level 1", 6'b100110);

    held = sw_cmd[5:0];
    set_ph(0, 3, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    chk(0, "R7 hold without strobe", held);

    for (int n = 0; n < 400; n++) begin
      v_bus = 16'($urandom_range(0, 20000)) - 16'd2000;
      for (int p = 0; p < NPH; p++)
        set_ph(p, int'($urandom_range(0, 3)),
               int'($urandom_range(0, 16000)) - 6000, int'($urandom_range(0, 16000)) - 6000,
               int'($urandom_range(0, 2000)) - 1000);
      strobe();
      for (int p = 0; p < NPH; p++) chk(p, "R8 random per phase", exp_ph(p));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule